// File: doc/BRIEF.md
# Gated Programmable Clock Output

This block derives a square-wave clock for external parts from the core clock. An 8-bit divider value N sets the length of each half period in core-clock cycles, so the output period is 2N core cycles with a 50% duty cycle. With a 40 MHz core clock, the output frequency is 40 MHz / (2 × N). A divider value of zero is read as 256.

The output runs only while three conditions hold together: the local enable is set, the host has finished configuring the device, and the device is not suspended. A start produces a full high phase. A stop is applied only at the end of a low phase, and in that case no further rising edge follows. The output therefore never emits a shortened pulse. A new divider value is sampled at each half-period boundary, so a change never cuts short the phase that is running.

Top module: `ckdiv_gated_out`

## Requirements
- R1: While reset is held and after it is released, `clk_out` is 0 until the run condition (`clk_en` = 1, `configured` = 1, `suspended` = 0) is sampled true.
- R2: While running with divider value N in 1..255, each high phase and each low phase of `clk_out` lasts exactly N core-clock cycles.
- R3: A divider value of 0x00 gives high and low phases of 256 core-clock cycles each.
- R4: From the stopped state, `clk_out` goes high on the first rising clock edge at which the run condition is sampled true, and that first high phase lasts the full N cycles.
- R5: If the run condition falls during a high phase, the high phase still completes its full N cycles. `clk_out` then stays 0 for as long as the condition is false.
- R6: If the run condition falls during a low phase, `clk_out` stays 0 and shows no further rising edge while the condition is false.
- R7: With `configured` = 0, or with `suspended` = 1, `clk_out` never rises even when `clk_en` = 1.
- R8: `div_val` is sampled at the clock edge that starts each half period. A change made in the middle of a phase leaves that phase at its old length, and the next phase uses the new value.
- R9: After a stop, restoring the run condition restarts the output with a full-length high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (base) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 8 | Half-period length in core cycles; 0 selects 256 |
| clk_en | input | 1 | Local enable for the output |
| configured | input | 1 | Host configuration complete |
| suspended | input | 1 | Device is in suspend |
| clk_out | output | 1 | Divided clock, held low while gated |

## Verification
`clk_out` is a register. It changes on the same rising edge at which the run condition or a half-period boundary is sampled, so every result is due one edge after its cause. The bench drives its inputs and samples the output on falling edges. A start applied at one falling edge is therefore checked at the next falling edge. Phase lengths are measured as runs of consecutive falling-edge samples and compared with the N that the bench derives from the divider value it applied, including 256 for zero.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   level;
    } gate_st_t;

endpackage

// File: rtl/ckdiv_halfcnt.sv
// Counts core cycles within one half period and flags the last cycle of it.
// A limit of zero wraps at 2**DIV_W through modular arithmetic.
module ckdiv_halfcnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             wrap_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    last;

    assign last   = (st_q.cnt == st_q.lim - DIV_W'(1));
    assign wrap_o = active_i && last;

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d.cnt = '0;
            st_d.lim = div_i;
        end else if (last) begin
            st_d.cnt = '0;
            st_d.lim = div_i;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: count never passes the latched limit (limit 0 means full range)
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lim == '0) || (st_q.cnt < st_q.lim));

    // R8: limit only changes at a boundary or while idle
    a_r8_lim_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !last) |=> $stable(st_q.lim));

endmodule

// File: rtl/ckdiv_gate.sv
// Phase sequencer: start into a full high phase, stop only at a low boundary.
module ckdiv_gate
    import ckdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_ok_i,
    input  logic wrap_i,
    output logic active_o,
    output logic level_o
);
    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: if (run_ok_i) st_d.phase = PH_HIGH;
            PH_HIGH: if (wrap_i)   st_d.phase = PH_LOW;
            PH_LOW:  if (wrap_i)   st_d.phase = run_ok_i ? PH_HIGH : PH_IDLE;
            default:               st_d.phase = PH_IDLE;
        endcase
        st_d.level = (st_d.phase == PH_HIGH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, level: 1'b0};
        else        st_q <= st_d;
    end

    assign active_o = (st_q.phase != PH_IDLE);
    assign level_o  = st_q.level;

    // R5 / R6 / R7: no rising edge while the run condition is false
    a_r5_no_rise_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.level && !run_ok_i) |=> !st_q.level);

    // R2: the phase only moves at a counter boundary while running
    a_r2_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !wrap_i) |=> $stable(st_q.phase));

    // R5: a high phase always ends into a low phase, never straight to idle
    a_r5_high_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HIGH && wrap_i) |=> (st_q.phase == PH_LOW));

endmodule

// File: rtl/ckdiv_gated_out.sv
module ckdiv_gated_out #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             clk_en,
    input  logic             configured,
    input  logic             suspended,
    output logic             clk_out
);
    logic run_ok;
    logic active;
    logic wrap;

    assign run_ok = clk_en && configured && !suspended;

    ckdiv_halfcnt #(.DIV_W(DIV_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .div_i    (div_val),
        .wrap_o   (wrap)
    );

    ckdiv_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_ok_i (run_ok),
        .wrap_i   (wrap),
        .active_o (active),
        .level_o  (clk_out)
    );

    // R4: stopped and run condition true -> output high on the next edge
    a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && run_ok) |=> clk_out);

    // R7: not configured keeps the output from rising
    a_r7_unconfigured_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_out && !configured) |=> !clk_out);

endmodule

// File: tb/ckdiv_gated_out_bench.sv
module ckdiv_gated_out_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_val = 8'd1;
    logic       clk_en = 1'b0;
    logic       configured = 1'b0;
    logic       suspended = 1'b0;
    logic       clk_out;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    ckdiv_gated_out u_ckdiv_gated_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_val    (div_val),
        .clk_en     (clk_en),
        .configured (configured),
        .suspended  (suspended),
        .clk_out    (clk_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count consecutive falling-edge samples equal to lvl, starting at the current one.
    task automatic measure(input logic lvl, output int len);
        len = 0;
        while (clk_out === lvl && len < 2000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic watch_low(input int n, input string req);
        int highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_out !== 1'b0) highs++;
        end
        check(highs == 0, req, highs, 0);
    endtask

    function automatic int eff(input logic [7:0] d);
        return (d == 8'd0) ? 256 : int'(d);
    endfunction

    // Start from stopped, measure high/low/high, stop in a low phase.
    task automatic run_one(input logic [7:0] d, input string req);
        int h1, l1, h2;
        div_val = d;
        clk_en  = 1'b1;
        @(negedge clk);
        check(clk_out === 1'b1, "R4 start edge", int'(clk_out), 1);
        measure(1'b1, h1);
        measure(1'b0, l1);
        measure(1'b1, h2);
        check(h1 == eff(d), req, h1, eff(d));
        check(l1 == eff(d), req, l1, eff(d));
        check(h2 == eff(d), req, h2, eff(d));
        clk_en = 1'b0;                 // now at the first low sample
        watch_low(600, "R6 stop in low phase");
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int h, l;
        repeat (3) @(negedge clk);
        check(clk_out === 1'b0, "R1 in reset", int'(clk_out), 0);
        rst_n = 1'b1;
        watch_low(10, "R1 after reset");

        // R7: enabled but unconfigured, then configured but suspended
        clk_en = 1'b1;
        watch_low(50, "R7 unconfigured");
        configured = 1'b1;
        suspended  = 1'b1;
        watch_low(50, "R7 suspended");
        clk_en    = 1'b0;
        suspended = 1'b0;
        @(negedge clk);

        // R2 sweep over small dividers plus the top value
        for (int d = 1; d <= 20; d++) run_one(8'(d), "R2 phase length");
        run_one(8'd255, "R2 phase length 255");
        // R3: zero means 256
        run_one(8'd0, "R3 zero divider");

        // R5: suspend during a high phase
        div_val = 8'd10;
        clk_en  = 1'b1;
        @(negedge clk);
        check(clk_out === 1'b1, "R4 start edge", int'(clk_out), 1);
        repeat (3) @(negedge clk);
        suspended = 1'b1;
        measure(1'b1, h);
        check(h == 7, "R5 high completes", h + 3, 10);
        watch_low(60, "R5 low after suspend");

        // R9: resume restarts with full high
        suspended = 1'b0;
        @(negedge clk);
        check(clk_out === 1'b1, "R9 restart edge", int'(clk_out), 1);
        measure(1'b1, h);
        check(h == 10, "R9 full high", h, 10);

        // R6: suspend part way into a low phase
        repeat (2) @(negedge clk);
        suspended = 1'b1;
        watch_low(60, "R6 suspend in low");
        suspended = 1'b0;
        clk_en    = 1'b0;
        watch_low(20, "R6 disabled");

        // R8: divider change mid high phase
        div_val = 8'd6;
        clk_en  = 1'b1;
        @(negedge clk);
        div_val = 8'd3;
        measure(1'b1, h);
        measure(1'b0, l);
        check(h == 6, "R8 old value holds", h, 6);
        check(l == 3, "R8 new value next phase", l, 3);
        measure(1'b1, h);
        check(h == 3, "R8 new value kept", h, 3);
        clk_en = 1'b0;
        watch_low(20, "R6 final stop");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule